// File: doc/BRIEF.md
# Dual-Processor Guarded Control Register

This block is one byte of control state that two processors share: a main processor and a coprocessor. Each reaches it through its own bus port, and each port decodes its own 16-byte address window. The stored bits drive the coprocessor's reset, interrupt, non-maskable interrupt and ready lines, and a write-protect level for the upper 32K of shared RAM. After a main-side reset the coprocessor is held in reset and not ready. It stays halted until the main processor programs the register.

The register protects read-modify-write sequences. A processor reads the byte, changes it and writes it back. That write is discarded if the other processor has written the register since this processor's last read. A discarded write sets that processor's failure flag. Both flags appear in the top two bits of every read, so software can test them with a single bit-test instruction and retry.

All traffic is plain single-cycle register strobes on one clock. There is no streaming data path, so neither port has a valid/ready handshake and neither ever applies back-pressure. A strobe is taken in the cycle it is seen. Read data is registered: it appears the cycle after the read strobe and holds until that port's next accepted read.

Top module: `dual_guard_ctrl_reg`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted write, the control outputs are all low: coprocessor reset and both interrupts asserted, ready low, write-protect off. Both failure flags, both staleness marks and both read-data registers are zero.
- R2: Register bit 0 drives `co_reset_n`, bit 1 drives `co_irq_n`, bit 2 drives `co_nmi_n`, bit 3 drives `co_ready` and bit 4 drives `upper_wp`. An accepted write updates the outputs on the clock edge that samples its strobe.
- R3: Bit 5 is a storage bit with no output, and it is read back as written. Reads return register bits 5:0 in data bits 5:0.
- R4: The main port responds only when `mn_sel` is high and `mn_addr[11:4]` equals 0xF0. The coprocessor port responds only when `co_sel` is high and `co_addr[15:4]` equals 0xEF0. Strobes outside these windows change nothing, including the read data.
- R5: A write is discarded when the other processor has had a write accepted since this processor's last read. Before any read, only writes accepted since reset count. An accepted write from one side marks the other side's read as stale.
- R6: A discarded write sets the writer's failure flag. Reads from either port show the coprocessor flag in bit 6 and the main flag in bit 7.
- R7: A read returns both flags as they stood before that clock edge. The same edge clears the reader's own failure flag and its staleness mark. If the other side's write is accepted in the same cycle, the staleness mark is set again.
- R8: When both ports write in the same cycle and the main write is accepted, the main data is stored and the coprocessor write counts as discarded.
- R9: Data bits 6 and 7 of a write are ignored, and those read bits always show the flags.
- R10: A port that raises read and write together in one cycle performs only the write. Its read data and its own failure flag are left unchanged.
- R11: The coprocessor can halt itself: an accepted coprocessor write that clears bit 3 drives `co_ready` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Main-side reset, active low, asynchronous |
| mn_sel | input | 1 | Main port chip select (I/O area) |
| mn_addr | input | 12 | Main port address |
| mn_rd | input | 1 | Main port read strobe |
| mn_wr | input | 1 | Main port write strobe |
| mn_wdata | input | 8 | Main port write data |
| mn_rdata | output | 8 | Main port read data (registered) |
| co_sel | input | 1 | Coprocessor port chip select |
| co_addr | input | 16 | Coprocessor port address |
| co_rd | input | 1 | Coprocessor port read strobe |
| co_wr | input | 1 | Coprocessor port write strobe |
| co_wdata | input | 8 | Coprocessor port write data |
| co_rdata | output | 8 | Coprocessor port read data (registered) |
| co_reset_n | output | 1 | Coprocessor reset, active low |
| co_irq_n | output | 1 | Coprocessor interrupt request, active low |
| co_nmi_n | output | 1 | Coprocessor non-maskable interrupt, active low |
| co_ready | output | 1 | Coprocessor ready |
| upper_wp | output | 1 | Write protect for upper 32K of shared RAM |

## Verification
The assertions check the guard on every cycle:
- a stale write leaves the stored byte untouched and raises the writer's flag;
- an accepted write marks the other side stale and stores its data;
- the main port wins a same-cycle contest;
- each read returns the pre-clear flags and leaves the reader's flag cleared.

The address windows, the mapping of bits to the control pins, the suppression of a read that shares a cycle with a write, and the reset state before and after release can only be shown by the bench. It drives full read-modify-write sequences from both sides and compares the pins and read data with values worked out by hand.

// File: rtl/dgcr_pkg.sv
package dgcr_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned STORE_W = 6;

  localparam int unsigned B_RESET_N = 0;
  localparam int unsigned B_IRQ_N   = 1;
  localparam int unsigned B_NMI_N   = 2;
  localparam int unsigned B_READY   = 3;
  localparam int unsigned B_WPROT   = 4;

  localparam int unsigned SIDES  = 2;
  localparam int unsigned S_MAIN = 0;
  localparam int unsigned S_COP  = 1;

  // Decoded, qualified access from one port.
  typedef struct packed {
    logic               rd;
    logic               wr;
    logic [STORE_W-1:0] wdata;
  } port_req_t;
endpackage

// File: rtl/dgcr_decode.sv
module dgcr_decode
  import dgcr_pkg::*;
#(
  parameter int unsigned    AW       = 12,
  parameter int unsigned    WIN_BITS = 4,
  parameter logic [AW-1:0]  BASE     = '0
) (
  input  logic              sel,
  input  logic [AW-1:0]     addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output port_req_t         req
);
  localparam int unsigned TAG_W = AW - WIN_BITS;

  logic [TAG_W-1:0] tag;
  logic             hit;
  logic             addr_low_unused;
  logic             wdata_hi_unused;

  assign tag             = addr[AW-1:WIN_BITS];
  assign hit             = sel && (tag == BASE[AW-1:WIN_BITS]);
  assign addr_low_unused = ^addr[WIN_BITS-1:0];
  assign wdata_hi_unused = ^wdata[BYTE_W-1:STORE_W];

  always_comb begin
    req.wr    = hit && wr;
    req.rd    = hit && rd && !wr;  // a write in the same cycle suppresses the read
    req.wdata = wdata[STORE_W-1:0];
  end
endmodule

// File: rtl/dgcr_guard.sv
module dgcr_guard
  import dgcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SIDES-1:0] rd,
  input  logic [SIDES-1:0] wr,
  output logic [SIDES-1:0] ok,
  output logic [SIDES-1:0] stale,
  output logic [SIDES-1:0] fail
);
  // Main side has fixed priority over the coprocessor.
  always_comb begin
    ok[S_MAIN] = wr[S_MAIN] && !stale[S_MAIN];
    ok[S_COP]  = wr[S_COP] && !stale[S_COP] && !ok[S_MAIN];
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int unsigned OTHER = SIDES - 1 - s;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stale[s] <= 1'b0;
      end else if (ok[OTHER]) begin
        stale[s] <= 1'b1;
      end else if (rd[s]) begin
        stale[s] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fail[s] <= 1'b0;
      end else if (wr[s] && !ok[s]) begin
        fail[s] <= 1'b1;
      end else if (rd[s]) begin
        fail[s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dgcr_store.sv
module dgcr_store
  import dgcr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mn_ok,
  input  logic               co_ok,
  input  logic [STORE_W-1:0] mn_data,
  input  logic [STORE_W-1:0] co_data,
  output logic [STORE_W-1:0] ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (mn_ok) begin
      ctrl_q <= mn_data;
    end else if (co_ok) begin
      ctrl_q <= co_data;
    end
  end
endmodule

// File: rtl/dgcr_readback.sv
module dgcr_readback
  import dgcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= status;
    end
  end
endmodule

// File: rtl/dual_guard_ctrl_reg.sv
module dual_guard_ctrl_reg
  import dgcr_pkg::*;
#(
  parameter int unsigned       MN_AW    = 12,
  parameter int unsigned       CO_AW    = 16,
  parameter int unsigned       WIN_BITS = 4,
  parameter logic [MN_AW-1:0]  MN_BASE  = 12'hF00,
  parameter logic [CO_AW-1:0]  CO_BASE  = 16'hEF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mn_sel,
  input  logic [MN_AW-1:0]  mn_addr,
  input  logic              mn_rd,
  input  logic              mn_wr,
  input  logic [BYTE_W-1:0] mn_wdata,
  output logic [BYTE_W-1:0] mn_rdata,
  input  logic              co_sel,
  input  logic [CO_AW-1:0]  co_addr,
  input  logic              co_rd,
  input  logic              co_wr,
  input  logic [BYTE_W-1:0] co_wdata,
  output logic [BYTE_W-1:0] co_rdata,
  output logic              co_reset_n,
  output logic              co_irq_n,
  output logic              co_nmi_n,
  output logic              co_ready,
  output logic              upper_wp
);
  port_req_t          mn_req;
  port_req_t          co_req;
  logic [SIDES-1:0]   rd_v;
  logic [SIDES-1:0]   wr_v;
  logic [SIDES-1:0]   ok_v;
  logic [SIDES-1:0]   stale_v;
  logic [SIDES-1:0]   fail_v;
  logic [STORE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0]  status;
  logic [BYTE_W-1:0]  rdata_v [SIDES];

  dgcr_decode #(.AW(MN_AW), .WIN_BITS(WIN_BITS), .BASE(MN_BASE)) u_mn_dec (
    .sel(mn_sel), .addr(mn_addr), .rd(mn_rd), .wr(mn_wr),
    .wdata(mn_wdata), .req(mn_req)
  );

  dgcr_decode #(.AW(CO_AW), .WIN_BITS(WIN_BITS), .BASE(CO_BASE)) u_co_dec (
    .sel(co_sel), .addr(co_addr), .rd(co_rd), .wr(co_wr),
    .wdata(co_wdata), .req(co_req)
  );

  assign rd_v[S_MAIN] = mn_req.rd;
  assign rd_v[S_COP]  = co_req.rd;
  assign wr_v[S_MAIN] = mn_req.wr;
  assign wr_v[S_COP]  = co_req.wr;

  dgcr_guard u_guard (
    .clk(clk), .rst_n(rst_n), .rd(rd_v), .wr(wr_v),
    .ok(ok_v), .stale(stale_v), .fail(fail_v)
  );

  dgcr_store u_store (
    .clk(clk), .rst_n(rst_n),
    .mn_ok(ok_v[S_MAIN]), .co_ok(ok_v[S_COP]),
    .mn_data(mn_req.wdata), .co_data(co_req.wdata),
    .ctrl_q(ctrl_q)
  );

  // Bit 7: main failure, bit 6: coprocessor failure, then stored bits.
  assign status = {fail_v[S_MAIN], fail_v[S_COP], ctrl_q};

  for (genvar s = 0; s < SIDES; s++) begin : g_rb
    dgcr_readback u_rb (
      .clk(clk), .rst_n(rst_n), .rd(rd_v[s]),
      .status(status), .rdata(rdata_v[s])
    );
  end

  assign mn_rdata   = rdata_v[S_MAIN];
  assign co_rdata   = rdata_v[S_COP];
  assign co_reset_n = ctrl_q[B_RESET_N];
  assign co_irq_n   = ctrl_q[B_IRQ_N];
  assign co_nmi_n   = ctrl_q[B_NMI_N];
  assign co_ready   = ctrl_q[B_READY];
  assign upper_wp   = ctrl_q[B_WPROT];
endmodule

// File: rtl/dgcr_checker.sv
module dgcr_checker
  import dgcr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               mn_wr_hit,
  input logic               co_wr_hit,
  input logic               mn_rd_hit,
  input logic               co_rd_hit,
  input logic               mn_ok,
  input logic               co_ok,
  input logic               stale_m,
  input logic               stale_c,
  input logic               fail_m,
  input logic               fail_c,
  input logic [STORE_W-1:0] ctrl_q,
  input logic [STORE_W-1:0] mn_wd,
  input logic [STORE_W-1:0] co_wd,
  input logic [BYTE_W-1:0]  mn_rdata,
  input logic [BYTE_W-1:0]  co_rdata
);
  // R5
  stale_main_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mn_wr_hit && stale_m && !co_wr_hit) |=> (ctrl_q == $past(ctrl_q)));

  // R5
  stale_cop_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (co_wr_hit && stale_c && !mn_wr_hit) |=> (ctrl_q == $past(ctrl_q)));

  // R5
  main_write_marks_cop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mn_ok |=> stale_c);

  // R5
  cop_write_marks_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    co_ok |=> stale_m);

  // R2
  main_write_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mn_ok |=> (ctrl_q == $past(mn_wd)));

  // R11
  cop_write_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    co_ok |=> (ctrl_q == $past(co_wd)));

  // R6
  main_fail_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mn_wr_hit && !mn_ok) |=> fail_m);

  // R6
  cop_fail_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (co_wr_hit && !co_ok) |=> fail_c);

  // R8
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mn_ok && co_ok));

  // R7
  main_read_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mn_rd_hit |=> (mn_rdata[7:6] == $past({fail_m, fail_c})) && !fail_m);

  // R7
  cop_read_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    co_rd_hit |=> (co_rdata[7:6] == $past({fail_m, fail_c})) && !fail_c);
endmodule

bind dual_guard_ctrl_reg dgcr_checker u_dgcr_chk (
  .clk(clk),
  .rst_n(rst_n),
  .mn_wr_hit(mn_req.wr),
  .co_wr_hit(co_req.wr),
  .mn_rd_hit(mn_req.rd),
  .co_rd_hit(co_req.rd),
  .mn_ok(ok_v[0]),
  .co_ok(ok_v[1]),
  .stale_m(stale_v[0]),
  .stale_c(stale_v[1]),
  .fail_m(fail_v[0]),
  .fail_c(fail_v[1]),
  .ctrl_q(ctrl_q),
  .mn_wd(mn_req.wdata),
  .co_wd(co_req.wdata),
  .mn_rdata(mn_rdata),
  .co_rdata(co_rdata)
);

// File: tb/dual_guard_ctrl_reg_bench.sv
module dual_guard_ctrl_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NV         = 25;

  // op: 0 idle, 1 read, 2 write, 3 read+write
  typedef struct packed {
    logic [1:0]  mop;
    logic [11:0] ma;
    logic [7:0]  md;
    logic [1:0]  cop;
    logic [15:0] ca;
    logic [7:0]  cd;
    logic [4:0]  eo;   // {wp, ready, nmi_n, irq_n, reset_n}
    logic [7:0]  emr;
    logic [7:0]  ecr;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{2'd2, 12'hF03, 8'h0F, 2'd0, 16'h0000, 8'h00, 5'h0F, 8'h00, 8'h00, 4'd2},  // R2 first write
    '{2'd0, 12'h000, 8'h00, 2'd1, 16'hEF07, 8'h00, 5'h0F, 8'h00, 8'h0F, 4'd7},  // R7 cop read
    '{2'd0, 12'h000, 8'h00, 2'd2, 16'hEF00, 8'h07, 5'h07, 8'h00, 8'h0F, 4'd11}, // R11 cop halts itself
    '{2'd2, 12'hF00, 8'h1F, 2'd0, 16'h0000, 8'h00, 5'h07, 8'h00, 8'h0F, 4'd5},  // R5 stale main write
    '{2'd0, 12'h000, 8'h00, 2'd1, 16'hEF00, 8'h00, 5'h07, 8'h00, 8'h87, 4'd6},  // R6 bit 7 seen by cop
    '{2'd1, 12'hF0F, 8'h00, 2'd0, 16'h0000, 8'h00, 5'h07, 8'h87, 8'h87, 4'd7},  // R7 pre-clear flag
    '{2'd1, 12'hF00, 8'h00, 2'd0, 16'h0000, 8'h00, 5'h07, 8'h07, 8'h87, 4'd7},  // R7 flag cleared
    '{2'd2, 12'hF0A, 8'hFF, 2'd0, 16'h0000, 8'h00, 5'h1F, 8'h07, 8'h87, 4'd9},  // R9 top bits dropped
    '{2'd1, 12'hF00, 8'h00, 2'd0, 16'h0000, 8'h00, 5'h1F, 8'h3F, 8'h87, 4'd3},  // R3 bit 5 stored
    '{2'd0, 12'h000, 8'h00, 2'd2, 16'hEF00, 8'h00, 5'h1F, 8'h3F, 8'h87, 4'd5},  // R5 stale cop write
    '{2'd1, 12'hF00, 8'h00, 2'd0, 16'h0000, 8'h00, 5'h1F, 8'h7F, 8'h87, 4'd6},  // R6 bit 6 seen by main
    '{2'd0, 12'h000, 8'h00, 2'd1, 16'hEF00, 8'h00, 5'h1F, 8'h7F, 8'h7F, 4'd7},  // R7
    '{2'd0, 12'h000, 8'h00, 2'd1, 16'hEF00, 8'h00, 5'h1F, 8'h7F, 8'h3F, 4'd7},  // R7
    '{2'd2, 12'hF10, 8'h00, 2'd2, 16'hEE00, 8'h00, 5'h1F, 8'h7F, 8'h3F, 4'd4},  // R4 writes outside
    '{2'd1, 12'h700, 8'h00, 2'd1, 16'hEF10, 8'h00, 5'h1F, 8'h7F, 8'h3F, 4'd4},  // R4 reads outside
    '{2'd2, 12'hF00, 8'h0B, 2'd2, 16'hEF00, 8'h0D, 5'h0B, 8'h7F, 8'h3F, 4'd8},  // R8 collision
    '{2'd0, 12'h000, 8'h00, 2'd1, 16'hEF00, 8'h00, 5'h0B, 8'h7F, 8'h4B, 4'd8},  // R8 cop flagged
    '{2'd3, 12'hF00, 8'h09, 2'd0, 16'h0000, 8'h00, 5'h09, 8'h7F, 8'h4B, 4'd10}, // R10 main rd+wr
    '{2'd0, 12'h000, 8'h00, 2'd3, 16'hEF00, 8'h19, 5'h09, 8'h7F, 8'h4B, 4'd10}, // R10 cop rd+wr
    '{2'd1, 12'hF00, 8'h00, 2'd0, 16'h0000, 8'h00, 5'h09, 8'h49, 8'h4B, 4'd10}, // R10 flag kept
    '{2'd0, 12'h000, 8'h00, 2'd1, 16'hEF00, 8'h00, 5'h09, 8'h49, 8'h49, 4'd6},  // R6
    '{2'd1, 12'hF00, 8'h00, 2'd0, 16'h0000, 8'h00, 5'h09, 8'h09, 8'h49, 4'd7},  // R7
    '{2'd1, 12'hF00, 8'h00, 2'd2, 16'hEF00, 8'h0F, 5'h0F, 8'h09, 8'h49, 4'd7},  // R7 read vs other write
    '{2'd2, 12'hF00, 8'h01, 2'd0, 16'h0000, 8'h00, 5'h0F, 8'h09, 8'h49, 4'd5},  // R5 re-marked stale
    '{2'd0, 12'h000, 8'h00, 2'd1, 16'hEF00, 8'h00, 5'h0F, 8'h09, 8'h8F, 4'd6}   // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mn_sel = 1'b0, mn_rd = 1'b0, mn_wr = 1'b0;
  logic [11:0] mn_addr = '0;
  logic [7:0]  mn_wdata = '0;
  logic [7:0]  mn_rdata;
  logic        co_sel = 1'b0, co_rd = 1'b0, co_wr = 1'b0;
  logic [15:0] co_addr = '0;
  logic [7:0]  co_wdata = '0;
  logic [7:0]  co_rdata;
  logic        co_reset_n, co_irq_n, co_nmi_n, co_ready, upper_wp;
  logic [4:0]  outs;
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          finished = 1'b0;

  assign outs = {upper_wp, co_ready, co_nmi_n, co_irq_n, co_reset_n};

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_guard_ctrl_reg u_dual_guard_ctrl_reg (
    .clk(clk), .rst_n(rst_n),
    .mn_sel(mn_sel), .mn_addr(mn_addr), .mn_rd(mn_rd), .mn_wr(mn_wr),
    .mn_wdata(mn_wdata), .mn_rdata(mn_rdata),
    .co_sel(co_sel), .co_addr(co_addr), .co_rd(co_rd), .co_wr(co_wr),
    .co_wdata(co_wdata), .co_rdata(co_rdata),
    .co_reset_n(co_reset_n), .co_irq_n(co_irq_n), .co_nmi_n(co_nmi_n),
    .co_ready(co_ready), .upper_wp(upper_wp)
  );

  task automatic check(input string what, input int rq, input int idx,
                       input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL R%0d step %0d %s: got %h expected %h", rq, idx, what, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] mop, input logic [11:0] ma, input logic [7:0] md,
                       input logic [1:0] cop, input logic [15:0] ca, input logic [7:0] cd);
    mn_sel = (mop != 2'd0); mn_rd = mop[0]; mn_wr = mop[1]; mn_addr = ma; mn_wdata = md;
    co_sel = (cop != 2'd0); co_rd = cop[0]; co_wr = cop[1]; co_addr = ca; co_wdata = cd;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired: got timeout expected completion");
    summary();
  end

  initial begin
    // R1: reset state while held and just after release
    repeat (3) @(negedge clk);
    check("outputs in reset", 1, 0, {3'b0, outs}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("outputs after release", 1, 0, {3'b0, outs}, 8'h00);
    check("main rdata after release", 1, 0, mn_rdata, 8'h00);
    check("cop rdata after release", 1, 0, co_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].mop, TBL[i].ma, TBL[i].md, TBL[i].cop, TBL[i].ca, TBL[i].cd);
      @(negedge clk);
      check("outputs", int'(TBL[i].req), i + 1, {3'b0, outs}, {3'b0, TBL[i].eo});
      check("main rdata", int'(TBL[i].req), i + 1, mn_rdata, TBL[i].emr);
      check("cop rdata", int'(TBL[i].req), i + 1, co_rdata, TBL[i].ecr);
    end
    drive(2'd0, '0, '0, 2'd0, '0, '0);

    // R1: reset in mid-run clears register, flags and read data
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("outputs in mid reset", 1, 100, {3'b0, outs}, 8'h00);
    check("main rdata in mid reset", 1, 100, mn_rdata, 8'h00);
    check("cop rdata in mid reset", 1, 100, co_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: main failure flag and stale mark gone, so a read shows zero
    drive(2'd1, 12'hF00, 8'h00, 2'd0, '0, '0);
    @(negedge clk);
    check("main read after reset", 1, 101, mn_rdata, 8'h00);
    // R2: write without a prior read is accepted after reset, releases coprocessor reset
    drive(2'd2, 12'hF05, 8'h01, 2'd0, '0, '0);
    @(negedge clk);
    check("reset_n released", 2, 102, {3'b0, outs}, 8'h01);
    // R2: ready and write protect set together
    drive(2'd2, 12'hF05, 8'h18, 2'd0, '0, '0);
    @(negedge clk);
    check("ready and wp", 2, 103, {3'b0, outs}, 8'h18);
    drive(2'd0, '0, '0, 2'd0, '0, '0);
    @(negedge clk);
    summary();
  end
endmodule